// File: doc/BRIEF.md
# Event Flag Combiner

This block captures system events into sticky flags, grouped into banks of equal width (four banks of thirty-two by default, 128 events). Event number `n` lives in bank `n / 32`, bit `n % 32`. A flag is set by a rising edge on its event input or by a write-one to the bank's set register. It stays set until software writes a one to the matching bit of the bank's clear register.

Each bank has two independent masks. In both, a mask bit of 1 blocks the flag and a 0 lets it through. The event mask gives a masked-flag view, and the OR of that view drives one combined event line per bank. These lines are event numbers 0 to 3 of the wider system. The exception mask gives a separate masked-exception view, and the OR of that view across all banks drives a single exception line. An exception is cleared through the same clear register as any other flag. Software reaches all of this through a plain register port. Reads are combinational. Writes take effect at the clock edge. There is no data stream, so the port has no valid/ready handshake and is never back-pressured.

Top module: `evt_combiner`

## Requirements
- R1: After reset, all flags read 0, every event mask and exception mask reads all ones, and `comb_evt` and `exc_out` are 0.
- R2: A 0-to-1 transition on `evt_in[n]` sets flag `n` at the next clock edge. An input held high does not set the flag again once it has been cleared.
- R3: Writing the set register of a bank sets every flag whose data bit is 1. Bits written as 0 have no effect.
- R4: Writing the clear register of a bank clears only the flags whose data bit is 1.
- R5: When a set (event edge or set write) and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: The masked-flag register of a bank reads flag AND NOT event-mask.
- R7: `comb_evt[b]` equals the OR of bank b's masked flags, registered one cycle after the flag or mask register changes.
- R8: The masked-exception register reads flag AND NOT exception-mask, and it does not depend on the event mask.
- R9: `exc_out` equals the OR of the masked-exception flags of all banks, registered one cycle after they change.
- R10: Clearing a flag through the clear register removes its exception, and `exc_out` falls one cycle later.
- R11: Address bits [1:0] select the bank and bits [4:2] select the register: 0 flags (read-only), 1 set (write-only), 2 clear (write-only), 3 event mask, 4 masked flags (read-only), 5 exception mask, 6 masked exceptions (read-only). Write-only and unused selectors read 0. Writes to read-only selectors change nothing.
- R12: Writing all ones to a bank's event mask and clear register leaves that bank's flags at 0 and its combined output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 128 | Event inputs, rising-edge detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: {selector, bank} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| comb_evt | output | 4 | Per-bank combined masked event level |
| exc_out | output | 1 | OR of all masked exception flags |

## Verification
A flag can receive a set and a clear in the same cycle. The bench provokes this by raising an event input at the same clock edge that a clear write targets that bit. It then reads the flag register back and expects the bit to be set. The bench also changes a mask and observes the combined line both in the cycle after the write and in the cycle after that. This confirms the output stays low for one cycle before it follows the new masked value.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_FLAG  = 3'd0,
    SEL_SET   = 3'd1,
    SEL_CLR   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_MFLAG = 3'd4,
    SEL_XMASK = 3'd5,
    SEL_XFLAG = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/evc_bank.sv
module evc_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] evt_in,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic              xmask_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] flag,
  output logic [BANK_W-1:0] mask,
  output logic [BANK_W-1:0] xmask,
  output logic [BANK_W-1:0] mflag,
  output logic [BANK_W-1:0] xmflag,
  output logic              comb,
  output logic              xany
);
  logic [BANK_W-1:0] evt_q, flag_q, mask_q, xmask_q;
  logic [BANK_W-1:0] rise, set_bits, clr_bits, flag_d;
  logic              comb_q, xany_q;

  // event edge capture
  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_in;
  end

  always_comb begin
    rise     = evt_in & ~evt_q;
    set_bits = rise | (set_we ? wdata : '0);
    clr_bits = clr_we ? wdata : '0;
    // set is applied after clear so it wins on a collision
    flag_d   = (flag_q & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      mask_q  <= '1;
      xmask_q <= '1;
    end else begin
      flag_q <= flag_d;
      if (mask_we)  mask_q  <= wdata;
      if (xmask_we) xmask_q <= wdata;
    end
  end

  assign mflag  = flag_q & ~mask_q;
  assign xmflag = flag_q & ~xmask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comb_q <= 1'b0;
      xany_q <= 1'b0;
    end else begin
      comb_q <= |mflag;
      xany_q <= |xmflag;
    end
  end

  assign flag  = flag_q;
  assign mask  = mask_q;
  assign xmask = xmask_q;
  assign comb  = comb_q;
  assign xany  = xany_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_bits & clr_bits)) |=> ((flag_q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits))); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_bits & ~set_bits)) |=> ((flag_q & $past(clr_bits & ~set_bits)) == '0)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_bits)) == $past(flag_q & ~clr_bits))); // R2
  AST_COMB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (comb == $past(|(flag & ~mask)))); // R7
endmodule

// File: rtl/evc_regdec.sv
module evc_regdec
  import evc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int BANK_AW   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [BANK_AW+SEL_W-1:0]         addr,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] flag_all,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_all,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] xmask_all,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] mflag_all,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] xmflag_all,
  output logic [NUM_BANKS-1:0]             set_we,
  output logic [NUM_BANKS-1:0]             clr_we,
  output logic [NUM_BANKS-1:0]             mask_we,
  output logic [NUM_BANKS-1:0]             xmask_we,
  output logic [BANK_W-1:0]                rdata
);
  reg_sel_e           sel;
  logic [BANK_AW-1:0] bidx;
  logic               bank_ok;

  assign sel     = reg_sel_e'(addr[BANK_AW+SEL_W-1:BANK_AW]);
  assign bidx    = addr[BANK_AW-1:0];
  assign bank_ok = (int'(bidx) < NUM_BANKS);

  always_comb begin
    set_we   = '0;
    clr_we   = '0;
    mask_we  = '0;
    xmask_we = '0;
    if (wr && bank_ok) begin
      unique case (sel)
        SEL_SET:   set_we[bidx]   = 1'b1;
        SEL_CLR:   clr_we[bidx]   = 1'b1;
        SEL_MASK:  mask_we[bidx]  = 1'b1;
        SEL_XMASK: xmask_we[bidx] = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (bank_ok) begin
      unique case (sel)
        SEL_FLAG:  rdata = flag_all[bidx];
        SEL_MASK:  rdata = mask_all[bidx];
        SEL_MFLAG: rdata = mflag_all[bidx];
        SEL_XMASK: rdata = xmask_all[bidx];
        SEL_XFLAG: rdata = xmflag_all[bidx];
        default:   rdata = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_we, clr_we, mask_we, xmask_we})); // R11
  AST_NO_WR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> ({set_we, clr_we, mask_we, xmask_we} == '0)); // R11
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
  import evc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]              evt_in,
  input  logic                                     reg_wr,
  input  logic [$clog2(NUM_BANKS)+SEL_W-1:0]       reg_addr,
  input  logic [BANK_W-1:0]                        reg_wdata,
  output logic [BANK_W-1:0]                        reg_rdata,
  output logic [NUM_BANKS-1:0]                     comb_evt,
  output logic                                     exc_out
);
  localparam int BANK_AW = $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0][BANK_W-1:0] flag_all, mask_all, xmask_all, mflag_all, xmflag_all;
  logic [NUM_BANKS-1:0]             set_we, clr_we, mask_we, xmask_we, xany;

  evc_regdec #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BANK_AW(BANK_AW)
  ) regdec_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .flag_all(flag_all), .mask_all(mask_all), .xmask_all(xmask_all),
    .mflag_all(mflag_all), .xmflag_all(xmflag_all),
    .set_we(set_we), .clr_we(clr_we), .mask_we(mask_we), .xmask_we(xmask_we),
    .rdata(reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    evc_bank #(.BANK_W(BANK_W)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .evt_in(evt_in[b*BANK_W +: BANK_W]),
      .set_we(set_we[b]), .clr_we(clr_we[b]),
      .mask_we(mask_we[b]), .xmask_we(xmask_we[b]),
      .wdata(reg_wdata),
      .flag(flag_all[b]), .mask(mask_all[b]), .xmask(xmask_all[b]),
      .mflag(mflag_all[b]), .xmflag(xmflag_all[b]),
      .comb(comb_evt[b]), .xany(xany[b])
    );
  end

  assign exc_out = |xany;

  AST_EXC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (exc_out == $past(|xmflag_all))); // R9
  AST_EXC_MASK_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|xmask_we) == 1'b0 && $past(rst_n)) |-> $stable(xmask_all)); // R8
endmodule

// File: tb/evt_combiner_tb.sv
module evt_combiner_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt_in = '0;
  logic         reg_wr = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   comb_evt;
  logic         exc_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .comb_evt(comb_evt), .exc_out(exc_out)
  );

  localparam logic [2:0] S_FLAG = 3'd0, S_SET = 3'd1, S_CLR = 3'd2, S_MASK = 3'd3,
                         S_MFLAG = 3'd4, S_XMASK = 3'd5, S_XFLAG = 3'd6, S_NONE = 3'd7;

  function automatic logic [4:0] ad(input logic [2:0] sel, input logic [1:0] bank);
    return {sel, bank};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic t_reset();
    for (int b = 0; b < 4; b++) begin
      rd_check("R1 flag", ad(S_FLAG, 2'(b)), 32'h0);
      rd_check("R1 mask", ad(S_MASK, 2'(b)), 32'hFFFF_FFFF);
      rd_check("R1 xmask", ad(S_XMASK, 2'(b)), 32'hFFFF_FFFF);
    end
    check("R1 comb_evt", {28'h0, comb_evt}, 32'h0);
    check("R1 exc_out", {31'h0, exc_out}, 32'h0);
  endtask

  task automatic t_edge();
    @(negedge clk); evt_in[37] = 1'b1;
    @(negedge clk);
    rd_check("R2 edge sets", ad(S_FLAG, 2'd1), 32'h20);
    wr(ad(S_CLR, 2'd1), 32'h20);
    @(negedge clk);
    rd_check("R2 held high no reset", ad(S_FLAG, 2'd1), 32'h0);
    evt_in[37] = 1'b0;
  endtask

  task automatic t_set_clr();
    wr(ad(S_SET, 2'd2), 32'h0000_00F0);
    rd_check("R3 set write", ad(S_FLAG, 2'd2), 32'h0000_00F0);
    wr(ad(S_FLAG, 2'd2), 32'h0);
    rd_check("R11 ro write ignored", ad(S_FLAG, 2'd2), 32'h0000_00F0);
    rd_check("R11 set reads 0", ad(S_SET, 2'd2), 32'h0);
    rd_check("R11 unused reads 0", ad(S_NONE, 2'd2), 32'h0);
    wr(ad(S_CLR, 2'd2), 32'h0000_0010);
    rd_check("R4 clear one bit", ad(S_FLAG, 2'd2), 32'h0000_00E0);
  endtask

  task automatic t_mask();
    rd_check("R6 masked all", ad(S_MFLAG, 2'd2), 32'h0);
    check("R7 comb masked", {31'h0, comb_evt[2]}, 32'h0);
    wr(ad(S_MASK, 2'd2), ~32'h40);
    rd_check("R6 mflag", ad(S_MFLAG, 2'd2), 32'h40);
    check("R7 comb latency", {31'h0, comb_evt[2]}, 32'h0);
    @(negedge clk);
    check("R7 comb high", {31'h0, comb_evt[2]}, 32'h1);
  endtask

  task automatic t_exc();
    rd_check("R8 xflag masked", ad(S_XFLAG, 2'd2), 32'h0);
    wr(ad(S_XMASK, 2'd2), ~32'h80);
    rd_check("R8 xflag", ad(S_XFLAG, 2'd2), 32'h80);
    rd_check("R8 event view unchanged", ad(S_MFLAG, 2'd2), 32'h40);
    check("R9 exc latency", {31'h0, exc_out}, 32'h0);
    @(negedge clk);
    check("R9 exc high", {31'h0, exc_out}, 32'h1);
    wr(ad(S_CLR, 2'd2), 32'h80);
    rd_check("R10 xflag cleared", ad(S_XFLAG, 2'd2), 32'h0);
    @(negedge clk);
    check("R10 exc low", {31'h0, exc_out}, 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    evt_in[3] = 1'b1;
    reg_wr = 1'b1; reg_addr = ad(S_CLR, 2'd0); reg_wdata = 32'h8;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_check("R5 set wins", ad(S_FLAG, 2'd0), 32'h8);
    evt_in[3] = 1'b0;
  endtask

  task automatic t_quiesce();
    wr(ad(S_SET, 2'd3), 32'hFF);
    wr(ad(S_MASK, 2'd3), 32'h0);
    @(negedge clk);
    check("R12 comb before", {31'h0, comb_evt[3]}, 32'h1);
    wr(ad(S_MASK, 2'd3), 32'hFFFF_FFFF);
    wr(ad(S_CLR, 2'd3), 32'hFFFF_FFFF);
    @(negedge clk);
    rd_check("R12 flags zero", ad(S_FLAG, 2'd3), 32'h0);
    check("R12 comb low", {31'h0, comb_evt[3]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_set_clr();
    t_mask();
    t_exc();
    t_collide();
    t_quiesce();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule